// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block watches over software running on the system clock. Software must service it at regular intervals, or it raises a reset request. Servicing is done through an 8-bit write-only service register. A bus write strobe, already qualified by the address decoder, carries one byte per write. A service counts only when two bytes arrive in order on consecutive writes: the opening key A5h and then the closing key 5Ah. Any other pattern is discarded, so a runaway program that happens to write the service register is unlikely to keep the system alive.

Timeout detection uses a prescaler that counts freely from reset and is never restarted by a service. A 2-bit period select picks one of four power-of-two tap periods. At each tap the block checks a pending flag. If the flag is clear, the block sets it. If the flag was already set, the block issues a one-clock reset request. Because the prescaler phase is independent of the service instant, the time from the last service to the request falls in a window of one to two tap periods. While any of the stop, sleep or hold state inputs is high, the pending flag is held clear, so the system cannot be reset while it is parked in a low-power state.

Top module: `wdt_keyed_top`

## Requirements
- R1: During and directly after reset, `rstReqOut` is low, the pending flag is clear, the key sequencer is idle and the prescaler is zero.
- R2: The tap period is 2^n clocks, with n = BASE_EXP + EXP_STEP*periodSel. With the defaults (15, 2), periodSel 00, 01, 10 and 11 give n = 15, 17, 19 and 21. Counting rising edges after reset release from 1, taps fall on the edges that are multiples of 2^n, using the select value present at that edge.
- R3: At a tap, a clear pending flag becomes set. A set flag instead produces a reset request. Left unserviced, the block raises `rstReqOut` after edges 2·2^n, 4·2^n, 6·2^n and so on.
- R4: A write of A5h followed, on the very next write, by a write of 5Ah clears the pending flag at the edge that captures the 5Ah write.
- R5: Any number of idle cycles may separate the A5h write from the 5Ah write without breaking the key pair.
- R6: A write of any byte other than A5h while idle, or of any byte other than 5Ah after A5h, returns the sequencer to idle and leaves the pending flag unchanged. This includes a repeated A5h and a lone 5Ah.
- R7: If the last valid service is captured at edge L, the next reset request rises at an edge L+d with 2^n < d <= 2^(n+1).
- R8: While `stopState`, `sleepState` or `holdState` is high, the pending flag is held clear and no reset request is produced. After release, timing resumes as if a service had happened at the last edge on which the input was high.
- R9: The reset request lasts exactly one clock. The edge that raises it also clears the pending flag and returns the key sequencer to idle.
- R10: If a valid 5Ah write and a tap land on the same edge while the flag is set, the service wins: no request is issued and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Service register write strobe, already address-decoded |
| wrData | input | 8 | Write data byte |
| periodSel | input | 2 | Tap period select |
| stopState | input | 1 | System is in stop state |
| sleepState | input | 1 | System is in sleep state |
| holdState | input | 1 | System is in bus hold state |
| rstReqOut | output | 1 | One-clock reset request |

## Verification
The pending flag and the key sequencer have no direct view at the ports. A wrong value in either one shows up only as a reset request on the wrong edge: one tap period early, one period late, or missing altogether. The bench therefore predicts the exact edge of every request from the tap grid and the edges of the last service or power-state release. Any deviation then surfaces within at most two tap periods. Scenarios with short, small-exponent periods cover mismatched keys, a delayed closing key, a key pair cut off by a request, a service that coincides with a tap, and each power-state input.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 8'h5A;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } keyState_e;

  // Strobes from the control section into the timing datapath.
  typedef struct packed {
    logic svcClear;
    logic pwrClear;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl
  import wdt_keyed_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [KEY_W-1:0] wrData,
  input  logic             stopState,
  input  logic             sleepState,
  input  logic             holdState,
  input  logic             biteEvt,
  output wdtStrobe_t       strobe,
  output logic             keyArmed
);

  keyState_e keyState;
  keyState_e keyNext;
  logic      openHit;
  logic      closeHit;
  logic      svcHit;

  assign openHit  = (wrData == KEY_OPEN);
  assign closeHit = (wrData == KEY_CLOSE);

  // Sequencer: every write leaves the armed state; only the opening key enters it.
  always_comb begin
    keyNext = keyState;
    svcHit  = 1'b0;
    if (wrEn) begin
      unique case (keyState)
        KEY_IDLE: begin
          keyNext = openHit ? KEY_ARMED : KEY_IDLE;
        end
        KEY_ARMED: begin
          keyNext = KEY_IDLE;
          svcHit  = closeHit;
        end
        default: keyNext = KEY_IDLE;
      endcase
    end
    if (biteEvt) begin
      keyNext = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
    end else begin
      keyState <= keyNext;
    end
  end

  assign strobe.svcClear = svcHit;
  assign strobe.pwrClear = stopState | sleepState | holdState;
  assign keyArmed        = (keyState == KEY_ARMED);

endmodule

// File: rtl/wdt_keyed_dpath.sv
module wdt_keyed_dpath
  import wdt_keyed_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int EXP_STEP = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] periodSel,
  input  wdtStrobe_t       strobe,
  output logic             rstReq,
  output logic             biteEvt,
  output logic             flagQ,
  output logic             tapEvt
);

  localparam int NUM_RANGES = 1 << SEL_W;
  localparam int MAX_EXP    = BASE_EXP + EXP_STEP * (NUM_RANGES - 1);
  localparam int CNT_W      = MAX_EXP;

  logic [CNT_W-1:0]      preCnt;
  logic [NUM_RANGES-1:0] tapVec;
  logic                  flagClear;

  // Free-running prescaler; a service never restarts it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // One tap per range: the low n bits are all ones just before they carry out.
  for (genvar rangeIdx = 0; rangeIdx < NUM_RANGES; rangeIdx++) begin : g_tap
    localparam int TAP_EXP = BASE_EXP + EXP_STEP * rangeIdx;
    assign tapVec[rangeIdx] = &preCnt[TAP_EXP-1:0];
  end

  assign tapEvt    = tapVec[periodSel];
  assign biteEvt   = tapEvt & flagQ & ~strobe.svcClear & ~strobe.pwrClear;
  assign flagClear = strobe.svcClear | strobe.pwrClear | biteEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= biteEvt;
      if (flagClear) begin
        flagQ <= 1'b0;
      end else if (tapEvt) begin
        flagQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int EXP_STEP = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic [SEL_W-1:0] periodSel,
  input  logic             stopState,
  input  logic             sleepState,
  input  logic             holdState,
  output logic             rstReqOut
);

  wdtStrobe_t ctrlBus;
  logic       biteEvt;
  logic       flagQ;
  logic       tapEvt;
  logic       keyArmed;

  wdt_keyed_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .stopState  (stopState),
    .sleepState (sleepState),
    .holdState  (holdState),
    .biteEvt    (biteEvt),
    .strobe     (ctrlBus),
    .keyArmed   (keyArmed)
  );

  wdt_keyed_dpath #(
    .BASE_EXP (BASE_EXP),
    .EXP_STEP (EXP_STEP),
    .SEL_W    (SEL_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .periodSel (periodSel),
    .strobe    (ctrlBus),
    .rstReq    (rstReqOut),
    .biteEvt   (biteEvt),
    .flagQ     (flagQ),
    .tapEvt    (tapEvt)
  );

endmodule

// File: rtl/wdt_keyed_checker.sv
module wdt_keyed_checker (
  input logic clk,
  input logic rstN,
  input logic rstReqOut,
  input logic flagQ,
  input logic tapEvt,
  input logic svcClear,
  input logic pwrClear,
  input logic keyArmed
);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> !rstReqOut);

  assert_bite_resets_state_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> (!flagQ && !keyArmed));

  assert_req_needs_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> $past(flagQ && tapEvt));

  assert_flag_set_on_tap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tapEvt && !flagQ && !svcClear && !pwrClear) |=> flagQ);

  assert_flag_rises_on_tap_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(tapEvt));

  assert_service_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    svcClear |=> !flagQ);

  assert_service_beats_tap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (svcClear && tapEvt) |=> !rstReqOut);

  assert_power_holds_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    pwrClear |=> (!flagQ && !rstReqOut));

endmodule

bind wdt_keyed_top wdt_keyed_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rstReqOut (rstReqOut),
  .flagQ     (flagQ),
  .tapEvt    (tapEvt),
  .svcClear  (ctrlBus.svcClear),
  .pwrClear  (ctrlBus.pwrClear),
  .keyArmed  (keyArmed)
);

// File: tb/wdt_keyed_top_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb_top;

  localparam int TB_BASE = 4;
  localparam int TB_STEP = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] periodSel = 2'b00;
  logic       stopState = 1'b0;
  logic       sleepState = 1'b0;
  logic       holdState = 1'b0;
  logic       rstReqOut;

  always #2 clk = ~clk;

  wdt_keyed_top #(.BASE_EXP(TB_BASE), .EXP_STEP(TB_STEP)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .periodSel  (periodSel),
    .stopState  (stopState),
    .sleepState (sleepState),
    .holdState  (holdState),
    .rstReqOut  (rstReqOut)
  );

  int    edgeCnt = 0;
  int    checks = 0;
  int    errors = 0;
  int    lastPulse = -1;
  bit    finished = 1'b0;
  int    expQ[$];
  string tagQ[$];

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: each observed request must match the oldest expected edge.
  always @(negedge clk) begin : monitor
    int    expEdge;
    string expTag;
    if (rstN && rstReqOut) begin
      lastPulse = edgeCnt;
      if (expQ.size() == 0) begin
        check(1'b0, "R3/R9 unexpected request edge", edgeCnt, -1);
      end else begin
        expEdge = expQ.pop_front();
        expTag  = tagQ.pop_front();
        check(expEdge == edgeCnt, expTag, edgeCnt, expEdge);
      end
    end
  end

  function automatic int periodOf(input int sel);
    return 1 << (TB_BASE + TB_STEP * sel);
  endfunction

  // First request after a flag clear at edge lastClr: one tap sets, the next fires.
  function automatic int nextPulse(input int lastClr, input int per);
    return ((lastClr / per) + 1) * per + per;
  endfunction

  task automatic expectPulse(input int edgeNo, input string tag);
    expQ.push_back(edgeNo);
    tagQ.push_back(tag);
  endtask

  task automatic applyReset(input logic [1:0] sel);
    @(negedge clk);
    rstN = 1'b0;
    periodSel = sel;
    wrEn = 1'b0;
    stopState = 1'b0;
    sleepState = 1'b0;
    holdState = 1'b0;
    repeat (2) @(negedge clk);
    check(rstReqOut == 1'b0, "R1 request low in reset", rstReqOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rstReqOut == 1'b0, "R1 request low after release", rstReqOut, 0);
  endtask

  task automatic waitEdge(input int target);
    while (edgeCnt < target) @(negedge clk);
  endtask

  // Drives one write; returns the edge that captured it.
  task automatic writeByte(input logic [7:0] d, output int capEdge);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    capEdge = edgeCnt;
    wrEn = 1'b0;
  endtask

  task automatic finishScenario(input string name);
    while (expQ.size() > 0) begin
      check(1'b0, {"R3 missing request in ", name}, -1, expQ.pop_front());
      void'(tagQ.pop_front());
    end
  endtask

  task automatic serviceRun(input int offset, input int pairs, output int lastSvc);
    int capE;
    waitEdge(edgeCnt + offset);
    for (int k = 0; k < pairs; k++) begin
      writeByte(8'hA5, capE);
      writeByte(8'h5A, lastSvc);
      waitEdge(edgeCnt + 8);
    end
  endtask

  task automatic powerRun(input int which);
    int relEdge;
    applyReset(2'b00);
    waitEdge(20);
    if (which == 0) stopState = 1'b1;
    else if (which == 1) sleepState = 1'b1;
    else holdState = 1'b1;
    waitEdge(70);
    relEdge = edgeCnt;
    stopState = 1'b0;
    sleepState = 1'b0;
    holdState = 1'b0;
    expectPulse(nextPulse(relEdge, periodOf(0)), "R8 timing after power release");
    waitEdge(nextPulse(relEdge, periodOf(0)) + 4);
    finishScenario("R8 power");
  endtask

  initial begin : driver
    int capE;
    int lastSvc;
    int p;

    // R1, R3: unserviced, shortest range
    applyReset(2'b00);
    expectPulse(32, "R3 first request");
    expectPulse(64, "R3 repeat request");
    expectPulse(96, "R3 third request");
    waitEdge(100);
    finishScenario("R3 unserviced");

    // R2: other period selects
    applyReset(2'b10);
    expectPulse(2 * periodOf(2), "R2 select 10 first");
    expectPulse(4 * periodOf(2), "R2 select 10 second");
    waitEdge(4 * periodOf(2) + 4);
    finishScenario("R2 sel 10");

    applyReset(2'b11);
    expectPulse(2 * periodOf(3), "R2 select 11 first");
    waitEdge(2 * periodOf(3) + 4);
    finishScenario("R2 sel 11");

    // R4, R7: regular service, then stop at two different phases
    for (int ph = 0; ph < 2; ph++) begin
      applyReset(2'b00);
      p = periodOf(0);
      serviceRun(3 + 7 * ph, 9, lastSvc);
      expectPulse(nextPulse(lastSvc, p), "R4 request after last service");
      waitEdge(nextPulse(lastSvc, p) + 4);
      check((lastPulse - lastSvc > p) && (lastPulse - lastSvc <= 2 * p),
            "R7 window from last service", lastPulse - lastSvc, 2 * p);
      finishScenario("R4 service");
    end

    // R5: long gap between keys, select 01
    applyReset(2'b01);
    p = periodOf(1);
    waitEdge(68);
    writeByte(8'hA5, capE);
    waitEdge(117);
    writeByte(8'h5A, lastSvc);
    expectPulse(nextPulse(lastSvc, p), "R5 delayed closing key");
    waitEdge(nextPulse(lastSvc, p) + 4);
    finishScenario("R5 gap");

    // R6: broken sequences leave the flag alone
    applyReset(2'b01);
    p = periodOf(1);
    waitEdge(68);
    writeByte(8'hA5, capE);
    writeByte(8'h00, capE);
    writeByte(8'h5A, capE);
    expectPulse(2 * p, "R6 wrong byte between keys");
    waitEdge(196);
    writeByte(8'hA5, capE);
    writeByte(8'hA5, capE);
    writeByte(8'h5A, capE);
    expectPulse(4 * p, "R6 repeated opening key");
    waitEdge(5 * p + 4);
    writeByte(8'h5A, capE);
    expectPulse(6 * p, "R6 lone closing key");
    waitEdge(6 * p + 4);
    finishScenario("R6 bad keys");

    // R8: each power-state input
    powerRun(0);
    powerRun(1);
    powerRun(2);

    // R9: request cancels a pending opening key
    applyReset(2'b00);
    waitEdge(24);
    writeByte(8'hA5, capE);
    expectPulse(32, "R9 request at 32");
    waitEdge(49);
    writeByte(8'h5A, capE);
    expectPulse(64, "R9 sequencer idled by request");
    waitEdge(70);
    finishScenario("R9 idle");

    // R10: service on the tap edge beats the request
    applyReset(2'b00);
    waitEdge(20);
    writeByte(8'hA5, capE);
    waitEdge(31);
    writeByte(8'h5A, lastSvc);
    check(lastSvc == 32, "R10 service captured on tap edge", lastSvc, 32);
    expectPulse(64, "R10 service wins over tap");
    waitEdge(70);
    finishScenario("R10 priority");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", edgeCnt, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule